// File: doc/BRIEF.md
# Paired-Page Translation Entry Permission Checker

This block takes one translation entry that a lookup has already matched, together with the virtual address being translated. It produces the physical address, the read, write and execute grants, and a 3-bit result code. Each entry maps two neighbouring pages, an even one and an odd one, which share the same page size. The block picks one of the two data words from the virtual address. It then checks the access against that word's attributes in a fixed priority order. If no check fails, it builds the physical address from the page number and the in-page offset.

The caller presents one strobed request. A request carries:
- the access kind: instruction fetch, data load or data store;
- the current privilege level;
- a 32/64-bit layout flag;
- a flag saying whether the entry came from the set-associative array, which has one global page size, or from the fully associative array, whose entries carry their own page size.

All outputs are registered and appear one cycle later with a one-cycle valid pulse. Searching the translation arrays, refilling them and raising exceptions are left to the surrounding logic.

Top module: `pte_perm_check`

## Requirements
- R1: The effective page size `ps` is `global_ps_i` when `set_assoc_i` is 1 and `entry_ps_i` when it is 0.
- R2: The odd data word is used when virtual address bit `ps` is 1; otherwise the even data word is used.
- R3: Faults are checked in this priority order, and the first one that applies wins; if none applies the access matches. The codes on `result_o` are: 1 invalid (V=0); 2 no-execute on a fetch (NX=1); 3 no-read on a load (NR=1); 4 privilege error; 5 not-dirty on a store (D=0); 0 match. Access codes are 0 fetch, 1 load and 2 store.
- R4: When RPLV=0, a privilege error is raised if the current level is numerically greater than the entry PLV. When RPLV=1, it is raised whenever the current level differs from the entry PLV.
- R5: The physical address is the page number shifted left by 12, ORed with the low `ps` bits of the virtual address. Before this, the page-number bits that stand for address bits 12 through ps-1 are cleared.
- R6: On a match, read is always granted, write is granted only when D=1, and execute only when NX=0. On any fault, all three grants and `pa_o` are 0.
- R7: In the 64-bit layout, the data word fields are: V bit 0, D bit 1, PLV bits 3:2, page number bits 47:12, NR bit 61, NX bit 62, RPLV bit 63. In the 32-bit layout, the page number is taken from bits 31:8, and NX, NR and RPLV are forced to 0.
- R8: `rsp_valid_o` is high exactly in the cycle after each cycle with `req_valid_i` high. The other outputs change only on such a response and otherwise hold their values.
- R9: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| va_i | input | VA_W | Virtual address |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| cur_plv_i | input | 2 | Current privilege level |
| mode64_i | input | 1 | 1 selects the 64-bit entry layout |
| set_assoc_i | input | 1 | 1 means the entry is set-associative and uses the global page size |
| global_ps_i | input | PS_W | Page size shared by all set-associative entries |
| entry_ps_i | input | PS_W | Page size carried by the entry |
| data_even_i | input | DATA_W | Data word for the even page |
| data_odd_i | input | DATA_W | Data word for the odd page |
| rsp_valid_o | output | 1 | Response pulse |
| pa_o | output | PA_W | Physical address |
| perm_r_o | output | 1 | Read granted |
| perm_w_o | output | 1 | Write granted |
| perm_x_o | output | 1 | Execute granted |
| result_o | output | 3 | Result code |

## Verification
The hardest case to reach is one where a lower-priority fault is hidden by a higher-priority one. An example is a store to a page that is not dirty but also lies outside the caller's privilege. The wrong word, or the wrong page-size source, can also slip by when both candidates happen to give the same answer.

To cover the first case, the stimulus sweeps every combination of access kind, caller level, entry level, RPLV, V, D, NX and NR. This produces every overlap of faults. To cover the second, every page-size sweep sets the page-size input that should not be used to a different value. The two data words are given different page numbers and different NX bits, so a wrong pick shows up in both the address and the execute grant.

// File: rtl/pte_pkg.sv
package pte_pkg;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_INVALID = 3'd1,
    RES_NOEXEC  = 3'd2,
    RES_NOREAD  = 3'd3,
    RES_PRIV    = 3'd4,
    RES_DIRTY   = 3'd5
  } res_e;

  // data word field positions
  localparam int unsigned POS_V     = 0;
  localparam int unsigned POS_D     = 1;
  localparam int unsigned POS_PLV   = 2;
  localparam int unsigned POS_PPN64 = 12;
  localparam int unsigned POS_PPN32 = 8;
  localparam int unsigned POS_NR    = 61;
  localparam int unsigned POS_NX    = 62;
  localparam int unsigned POS_RPLV  = 63;

  localparam int unsigned PAGE_LSB  = 12;

  typedef struct packed {
    logic       v;
    logic       d;
    logic [1:0] plv;
    logic       nx;
    logic       nr;
    logic       rplv;
  } attr_t;

endpackage

// File: rtl/pte_half_sel.sv
module pte_half_sel #(
  parameter int unsigned VA_W   = 48,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned PS_W   = 6
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic              set_assoc_i,
  input  logic [PS_W-1:0]   global_ps_i,
  input  logic [PS_W-1:0]   entry_ps_i,
  input  logic [DATA_W-1:0] even_i,
  input  logic [DATA_W-1:0] odd_i,
  output logic [PS_W-1:0]   ps_o,
  output logic [DATA_W-1:0] word_o
);

  logic odd_sel;

  assign ps_o    = set_assoc_i ? global_ps_i : entry_ps_i;
  // a shift past the top of the address yields 0, so the even page is used
  assign odd_sel = |(va_i & (VA_W'(1) << ps_o));
  assign word_o  = odd_sel ? odd_i : even_i;

endmodule

// File: rtl/pte_field_dec.sv
module pte_field_dec
  import pte_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned PPN_W   = 36,
  parameter int unsigned PPN32_W = 24
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              mode64_i,
  output attr_t             attr_o,
  output logic [PPN_W-1:0]  ppn_o
);

  logic unused_word;
  assign unused_word = ^word_i;

  always_comb begin
    attr_o.v   = word_i[POS_V];
    attr_o.d   = word_i[POS_D];
    attr_o.plv = word_i[POS_PLV +: 2];
    if (mode64_i) begin
      attr_o.nx   = word_i[POS_NX];
      attr_o.nr   = word_i[POS_NR];
      attr_o.rplv = word_i[POS_RPLV];
      ppn_o       = word_i[POS_PPN64 +: PPN_W];
    end else begin
      attr_o.nx   = 1'b0;
      attr_o.nr   = 1'b0;
      attr_o.rplv = 1'b0;
      ppn_o       = PPN_W'(word_i[POS_PPN32 +: PPN32_W]);
    end
  end

endmodule

// File: rtl/pte_fault_ladder.sv
module pte_fault_ladder
  import pte_pkg::*;
(
  input  attr_t      attr_i,
  input  logic [1:0] acc_i,
  input  logic [1:0] plv_i,
  output res_e       res_o
);

  logic priv_bad;

  assign priv_bad = attr_i.rplv ? (plv_i != attr_i.plv) : (plv_i > attr_i.plv);

  always_comb begin
    if (!attr_i.v)                            res_o = RES_INVALID;
    else if (acc_i == ACC_FETCH && attr_i.nx) res_o = RES_NOEXEC;
    else if (acc_i == ACC_LOAD && attr_i.nr)  res_o = RES_NOREAD;
    else if (priv_bad)                        res_o = RES_PRIV;
    else if (acc_i == ACC_STORE && !attr_i.d) res_o = RES_DIRTY;
    else                                      res_o = RES_OK;
  end

endmodule

// File: rtl/pte_addr_form.sv
module pte_addr_form
  import pte_pkg::*;
#(
  parameter int unsigned VA_W  = 48,
  parameter int unsigned PA_W  = 48,
  parameter int unsigned PS_W  = 6,
  parameter int unsigned PPN_W = PA_W - PAGE_LSB
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [PPN_W-1:0] ppn_i,
  output logic [PA_W-1:0]  pa_o
);

  logic [PS_W-1:0]  sw_n;
  logic [PPN_W-1:0] keep;
  logic [PPN_W-1:0] ppn_clr;
  logic [VA_W-1:0]  va_lo;

  assign sw_n = (ps_i > PS_W'(PAGE_LSB)) ? ps_i - PS_W'(PAGE_LSB) : '0;

  // page-number bits below the page size belong to software
  for (genvar k = 0; k < PPN_W; k++) begin : g_keep
    assign keep[k] = (sw_n <= PS_W'(k));
  end

  assign ppn_clr = ppn_i & keep;
  assign va_lo   = va_i & ~({VA_W{1'b1}} << ps_i);
  assign pa_o    = {ppn_clr, {PAGE_LSB{1'b0}}} | PA_W'(va_lo);

endmodule

// File: rtl/pte_perm_check.sv
module pte_perm_check
  import pte_pkg::*;
#(
  parameter int unsigned VA_W    = 48,
  parameter int unsigned PA_W    = 48,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned PS_W    = 6,
  parameter int unsigned PPN32_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [1:0]        acc_i,
  input  logic [1:0]        cur_plv_i,
  input  logic              mode64_i,
  input  logic              set_assoc_i,
  input  logic [PS_W-1:0]   global_ps_i,
  input  logic [PS_W-1:0]   entry_ps_i,
  input  logic [DATA_W-1:0] data_even_i,
  input  logic [DATA_W-1:0] data_odd_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   pa_o,
  output logic              perm_r_o,
  output logic              perm_w_o,
  output logic              perm_x_o,
  output logic [2:0]        result_o
);

  localparam int unsigned PPN_W = PA_W - PAGE_LSB;

  logic [PS_W-1:0]   ps;
  logic [DATA_W-1:0] word;
  attr_t             attr;
  logic [PPN_W-1:0]  ppn;
  logic [PA_W-1:0]   pa_c;
  res_e              res;

  pte_half_sel #(.VA_W(VA_W), .DATA_W(DATA_W), .PS_W(PS_W)) i_half_sel (
    .va_i        (va_i),
    .set_assoc_i (set_assoc_i),
    .global_ps_i (global_ps_i),
    .entry_ps_i  (entry_ps_i),
    .even_i      (data_even_i),
    .odd_i       (data_odd_i),
    .ps_o        (ps),
    .word_o      (word)
  );

  pte_field_dec #(.DATA_W(DATA_W), .PPN_W(PPN_W), .PPN32_W(PPN32_W)) i_field_dec (
    .word_i   (word),
    .mode64_i (mode64_i),
    .attr_o   (attr),
    .ppn_o    (ppn)
  );

  pte_fault_ladder i_fault_ladder (
    .attr_i (attr),
    .acc_i  (acc_i),
    .plv_i  (cur_plv_i),
    .res_o  (res)
  );

  pte_addr_form #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W), .PPN_W(PPN_W)) i_addr_form (
    .va_i  (va_i),
    .ps_i  (ps),
    .ppn_i (ppn),
    .pa_o  (pa_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      pa_o        <= '0;
      perm_r_o    <= 1'b0;
      perm_w_o    <= 1'b0;
      perm_x_o    <= 1'b0;
      result_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        result_o <= res;
        if (res == RES_OK) begin
          pa_o     <= pa_c;
          perm_r_o <= 1'b1;
          perm_w_o <= attr.d;
          perm_x_o <= !attr.nx;
        end else begin
          pa_o     <= '0;
          perm_r_o <= 1'b0;
          perm_w_o <= 1'b0;
          perm_x_o <= 1'b0;
        end
      end
    end
  end

endmodule

module pte_perm_check_sva
  import pte_pkg::*;
#(
  parameter int unsigned VA_W = 48,
  parameter int unsigned PA_W = 48
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [VA_W-1:0] va_i,
  input logic [1:0]      acc_i,
  input logic            rsp_valid_o,
  input logic [PA_W-1:0] pa_o,
  input logic            perm_r_o,
  input logic            perm_w_o,
  input logic            perm_x_o,
  input logic [2:0]      result_o
);

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(pa_o) && $stable(result_o) && $stable(perm_w_o)));

  p_code_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (result_o <= 3'd5));

  p_noexec_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && result_o == 3'd2) |-> ($past(acc_i) == ACC_FETCH));

  p_noread_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && result_o == 3'd3) |-> ($past(acc_i) == ACC_LOAD));

  p_dirty_store_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && result_o == 3'd5) |-> ($past(acc_i) == ACC_STORE));

  p_fault_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && result_o != 3'd0) |->
      (!perm_r_o && !perm_w_o && !perm_x_o && pa_o == '0));

  p_read_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && result_o == 3'd0) |-> perm_r_o);

  p_offset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && result_o == 3'd0) |-> (pa_o[11:0] == $past(va_i[11:0])));

endmodule

bind pte_perm_check pte_perm_check_sva #(.VA_W(VA_W), .PA_W(PA_W)) i_pte_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .va_i        (va_i),
  .acc_i       (acc_i),
  .rsp_valid_o (rsp_valid_o),
  .pa_o        (pa_o),
  .perm_r_o    (perm_r_o),
  .perm_w_o    (perm_w_o),
  .perm_x_o    (perm_x_o),
  .result_o    (result_o)
);

// File: tb/test_pte_perm_check.sv
module test_pte_perm_check;

  localparam int VA_W = 48;
  localparam int PA_W = 48;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [47:0] va_i = '0;
  logic [1:0]  acc_i = '0;
  logic [1:0]  cur_plv_i = '0;
  logic        mode64_i = 1'b0;
  logic        set_assoc_i = 1'b0;
  logic [5:0]  global_ps_i = '0;
  logic [5:0]  entry_ps_i = '0;
  logic [63:0] data_even_i = '0;
  logic [63:0] data_odd_i = '0;
  logic        rsp_valid_o;
  logic [47:0] pa_o;
  logic        perm_r_o, perm_w_o, perm_x_o;
  logic [2:0]  result_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  longint unsigned seed = 64'h1234_5678_9abc_def1;

  always #5 clk_i = ~clk_i;

  pte_perm_check i_pte_perm_check (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .va_i(va_i),
    .acc_i(acc_i), .cur_plv_i(cur_plv_i), .mode64_i(mode64_i),
    .set_assoc_i(set_assoc_i), .global_ps_i(global_ps_i), .entry_ps_i(entry_ps_i),
    .data_even_i(data_even_i), .data_odd_i(data_odd_i), .rsp_valid_o(rsp_valid_o),
    .pa_o(pa_o), .perm_r_o(perm_r_o), .perm_w_o(perm_w_o), .perm_x_o(perm_x_o),
    .result_o(result_o)
  );

  function automatic logic [63:0] rnd();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk64(bit v, bit d, logic [1:0] plv, bit nx, bit nr,
                                       bit rplv, logic [35:0] ppn);
    logic [63:0] w = '0;
    w[0] = v; w[1] = d; w[3:2] = plv; w[47:12] = ppn;
    w[61] = nr; w[62] = nx; w[63] = rplv;
    return w;
  endfunction

  // expected response packed as {result[2:0], r, w, x, pa[47:0]}
  function automatic logic [53:0] model();
    int unsigned ps;
    logic [63:0] w;
    logic [63:0] ppn;
    bit v, d, nx, nr, rplv, bad;
    logic [1:0] plv;
    logic [2:0] res;
    logic [63:0] pa;
    ps = set_assoc_i ? global_ps_i : entry_ps_i;                      // R1
    w = (((64'(va_i) >> ps) & 64'd1) != 0) ? data_odd_i : data_even_i; // R2
    v = w[0]; d = w[1]; plv = w[3:2];
    if (mode64_i) begin
      ppn = 64'(w[47:12]); nr = w[61]; nx = w[62]; rplv = w[63];
    end else begin
      ppn = 64'(w[31:8]); nr = 0; nx = 0; rplv = 0;                   // R7
    end
    if (ps > 12) ppn = ppn & ~((64'd1 << (ps - 12)) - 64'd1);
    bad = rplv ? (cur_plv_i != plv) : (cur_plv_i > plv);              // R4
    if (!v) res = 3'd1;
    else if (acc_i == 2'd0 && nx) res = 3'd2;
    else if (acc_i == 2'd1 && nr) res = 3'd3;
    else if (bad) res = 3'd4;
    else if (acc_i == 2'd2 && !d) res = 3'd5;
    else res = 3'd0;
    if (res == 3'd0) begin
      pa = (ppn << 12) | (64'(va_i) & ((64'd1 << ps) - 64'd1));        // R5
      return {res, 1'b1, d, !nx, pa[47:0]};                            // R6
    end
    return {res, 3'b000, 48'd0};
  endfunction

  task automatic run(string tag);
    logic [53:0] exp;
    logic [47:0] pa_hold;
    exp = model();
    @(negedge clk_i);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check({tag, " response"}, 64'({rsp_valid_o, result_o, perm_r_o, perm_w_o, perm_x_o, pa_o}),
          64'({1'b1, exp}));
    pa_hold = pa_o;
    data_even_i = ~data_even_i;
    data_odd_i  = ~data_odd_i;
    @(negedge clk_i);
    check("R8 pulse and hold", 64'({rsp_valid_o, result_o, pa_o}),
          64'({1'b0, exp[53:51], pa_hold}));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 reset state", 64'({rsp_valid_o, result_o, perm_r_o, perm_w_o, perm_x_o, pa_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 R4 R6: full attribute / access / level sweep, 64-bit layout
    mode64_i = 1; set_assoc_i = 1; global_ps_i = 6'd14; entry_ps_i = 6'd20;
    for (int a = 0; a < 3; a++)
      for (int cp = 0; cp < 4; cp++)
        for (int ep = 0; ep < 4; ep++)
          for (int attr = 0; attr < 32; attr++) begin
            acc_i = 2'(a); cur_plv_i = 2'(cp);
            va_i = rnd()[47:0];
            va_i[14] = 1'b0;
            data_even_i = mk64(attr[0], attr[1], 2'(ep), attr[2], attr[3], attr[4], rnd()[35:0]);
            data_odd_i  = mk64(1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, rnd()[35:0]);
            run("R3 R4 R6 ladder");
          end

    // R1 R2 R5: page-size source, half select, page-number clearing
    for (int ps = 12; ps < 31; ps++)
      for (int sa = 0; sa < 2; sa++)
        for (int h = 0; h < 2; h++)
          for (int n = 0; n < 2; n++) begin
            acc_i = 2'd1; cur_plv_i = 2'd0; set_assoc_i = sa[0];
            if (sa != 0) begin global_ps_i = 6'(ps); entry_ps_i = 6'(ps + 1); end
            else begin entry_ps_i = 6'(ps); global_ps_i = 6'(ps + 1); end
            va_i = rnd()[47:0];
            va_i[ps] = h[0];
            va_i[ps + 1] = ~h[0];
            data_even_i = mk64(1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, rnd()[35:0]);
            data_odd_i  = mk64(1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, rnd()[35:0]);
            run("R1 R2 R5 page size");
          end

    // R7: 32-bit layout ignores high attribute bits
    mode64_i = 0; set_assoc_i = 0;
    for (int a = 0; a < 3; a++)
      for (int cp = 0; cp < 4; cp++)
        for (int ep = 0; ep < 4; ep++) begin
          acc_i = 2'(a); cur_plv_i = 2'(cp);
          entry_ps_i = 6'(12 + (ep + cp) % 3);
          va_i = rnd()[47:0];
          data_even_i = rnd();
          data_even_i[0] = 1'b1; data_even_i[3:2] = 2'(ep); data_even_i[63:61] = 3'b111;
          data_odd_i = data_even_i;
          run("R7 narrow layout");
        end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule